// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block produces a periodic interrupt from a 32.768 kHz time base that reaches it as a one-cycle enable on the system clock. A free-running base count advances on each enabled base tick. A 4-bit rate code picks a period that is a power of two of base ticks. An event fires when the base count steps onto a whole multiple of the selected period, so events stay locked to the base count and are not timed from the moment the code was written.

Each event sets a sticky periodic flag and raises a one-cycle request pulse for the shared interrupt line. Events happen only while the periodic enable input is high and the rate code is nonzero. A clear strobe from the status-register read path removes the flag. A 3-bit divider-control field decides whether the base count runs, holds its value, or is held at zero.

Top module: `periodic_rate_gen`

## Requirements
- R1: After reset, `per_flag` and `req_pulse` are 0 and the base count is 0.
- R2: For rate codes 3 to 15, consecutive events are exactly 2^(code-1) base ticks apart.
- R3: Rate codes 1 and 2 act as codes 8 and 9, so their periods are 128 and 256 base ticks.
- R4: Rate code 0 produces no events, and the flag is never set.
- R5: An event fires on the base tick that moves the base count (16 bits, counted from reset or from the last divider clear) onto a multiple of the period. A new rate code applies from the next tick onwards.
- R6: With `pie_en` low, no event occurs and neither `per_flag` nor `req_pulse` is raised.
- R7: An event raises `req_pulse` for exactly one clock cycle, in the cycle after the clock edge that samples the tick, and sets `per_flag` in that same cycle.
- R8: `per_flag` stays set until `flag_clr` is high at a clock edge. When a clear and an event meet at the same edge, the flag stays set.
- R9: Divider-control values 0 to 2 let the base count run. Values 3 to 5 freeze it. Values 6 and 7 force it to 0 and hold it there.
- R10: The base count advances only at clock edges where `tick_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable per 32.768 kHz base tick |
| rate_sel | input | 4 | Rate code; 0 disables events |
| div_sel | input | 3 | Divider control: run, freeze or clear the base count |
| pie_en | input | 1 | Periodic enable |
| flag_clr | input | 1 | Clear strobe for the periodic flag |
| per_flag | output | 1 | Sticky periodic flag |
| req_pulse | output | 1 | One-cycle interrupt request |

## Verification
Both outputs are registered at the same clock edge that advances the base count, so a tick sampled at one rising edge shows up on `per_flag` and `req_pulse` just after that edge. A clear strobe acts at the edge that samples it in the same way. The bench drives every input on the falling edge, moves to the next rising edge, and reads the outputs at the following falling edge, so each observation reflects exactly one sampled edge. It keeps its own model of the base count, which is reset and advanced from the inputs it drives, and from that model it predicts the tick on which each event is due.

// File: rtl/prg_pkg.sv
package prg_pkg;

  typedef enum logic [1:0] {
    DIV_RUN   = 2'd0,
    DIV_HOLD  = 2'd1,
    DIV_CLEAR = 2'd2
  } div_mode_e;

  localparam int unsigned DIV_W       = 3;
  localparam int unsigned DIV_RUN_MAX = 2;

  // upper two bits both set -> count held at zero; low values run; rest freeze
  function automatic div_mode_e div_decode(input logic [DIV_W-1:0] d);
    div_mode_e m;
    if (d[DIV_W-1:DIV_W-2] == 2'b11) begin
      m = DIV_CLEAR;
    end else if (d <= DIV_W'(DIV_RUN_MAX)) begin
      m = DIV_RUN;
    end else begin
      m = DIV_HOLD;
    end
    return m;
  endfunction

endpackage

// File: rtl/prg_reset_sync.sv
module prg_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/prg_base_counter.sv
module prg_base_counter
  import prg_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  div_mode_e        mode,
  output logic             adv,
  output logic [CNT_W-1:0] cnt_nxt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    adv     = tick_en && (mode == DIV_RUN);
    cnt_nxt = cnt_q + CNT_W'(1);
    cnt_d   = cnt_q;
    if (mode == DIV_CLEAR) begin
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DIV_CLEAR) |=> (cnt_q == '0));

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DIV_HOLD) |=> $stable(cnt_q));

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && mode != DIV_CLEAR) |=> $stable(cnt_q));

endmodule

// File: rtl/prg_rate_decode.sv
module prg_rate_decode #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CODE_W = 4
) (
  input  logic [CODE_W-1:0] rate_sel,
  input  logic              pie_en,
  output logic              active,
  output logic [CNT_W-1:0]  phase_mask
);

  localparam logic [CODE_W-1:0] ALIAS_LO = CODE_W'(8);
  localparam logic [CODE_W-1:0] ALIAS_HI = CODE_W'(9);

  logic [CODE_W-1:0] eff_code;
  logic [CODE_W-1:0] shift;

  always_comb begin
    unique case (rate_sel)
      CODE_W'(1): eff_code = ALIAS_LO;
      CODE_W'(2): eff_code = ALIAS_HI;
      default:    eff_code = rate_sel;
    endcase
    shift  = eff_code - CODE_W'(1);
    active = pie_en && (rate_sel != '0);
  end

  // bits below the period bit form the phase mask
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign phase_mask[i] = (CODE_W'(i) < shift);
  end

endmodule

// File: rtl/prg_event_flag.sv
module prg_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic flag_clr,
  output logic per_flag,
  output logic req_pulse
);

  logic flag_q, flag_d;
  logic pulse_q, pulse_d;

  always_comb begin
    flag_d  = fire | (flag_q & ~flag_clr);
    pulse_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
    end
  end

  assign per_flag  = flag_q;
  assign req_pulse = pulse_q;

  assert_pulse_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |-> per_flag);

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |=> !req_pulse);

  assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (per_flag && !flag_clr) |=> per_flag);

endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen
  import prg_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [CODE_W-1:0] rate_sel,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              pie_en,
  input  logic              flag_clr,
  output logic              per_flag,
  output logic              req_pulse
);

  logic             rst_sync_n;
  div_mode_e        mode;
  logic             adv;
  logic [CNT_W-1:0] cnt_nxt;
  logic             active;
  logic [CNT_W-1:0] phase_mask;
  logic             fire;

  prg_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    mode = div_decode(div_sel);
  end

  prg_base_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_en (tick_en),
    .mode    (mode),
    .adv     (adv),
    .cnt_nxt (cnt_nxt)
  );

  prg_rate_decode #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_dec (
    .rate_sel   (rate_sel),
    .pie_en     (pie_en),
    .active     (active),
    .phase_mask (phase_mask)
  );

  always_comb begin
    fire = adv && active && ((cnt_nxt & phase_mask) == '0);
  end

  prg_event_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fire      (fire),
    .flag_clr  (flag_clr),
    .per_flag  (per_flag),
    .req_pulse (req_pulse)
  );

  assert_no_req_disabled_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_pulse |-> $past(pie_en));

  assert_no_req_code0_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_pulse |-> ($past(rate_sel) != '0));

  assert_req_needs_tick_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_pulse |-> $past(tick_en));

endmodule

// File: tb/periodic_rate_gen_bench.sv
module periodic_rate_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic [3:0] rate_sel;
  logic [2:0] div_sel;
  logic       pie_en;
  logic       flag_clr;
  logic       per_flag;
  logic       req_pulse;

  int checks = 0;
  int fails  = 0;
  logic [15:0] m_cnt;

  always #4 clk = ~clk;

  periodic_rate_gen u_periodic_rate_gen (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_sel(rate_sel),
    .div_sel(div_sel), .pie_en(pie_en), .flag_clr(flag_clr),
    .per_flag(per_flag), .req_pulse(req_pulse)
  );

  // model of the base count, from R9/R10
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_cnt <= '0;
    else if (div_sel >= 3'd6) m_cnt <= '0;
    else if (tick_en && div_sel <= 3'd2) m_cnt <= m_cnt + 16'd1;
  end

  // expected period per code (index = code)
  localparam int unsigned EXP_PER [1:15] = '{128, 256, 4, 8, 16, 32, 64, 128,
                                             256, 512, 1024, 2048, 4096, 8192, 16384};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit t, input bit c);
    tick_en  = t;
    flag_clr = c;
    @(posedge clk);
    @(negedge clk);
    tick_en  = 1'b0;
    flag_clr = 1'b0;
  endtask

  task automatic wait_event(input int limit, input bit alt, output int ticks, output bit seen);
    ticks = 0;
    seen  = 1'b0;
    for (int i = 0; i < limit; i++) begin
      bit t;
      t = alt ? bit'(i % 2) : 1'b1;
      step(t, 1'b0);
      if (t) ticks++;
      if (req_pulse) begin
        seen = 1'b1;
        return;
      end
    end
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int  tk;
    bit  sn;
    int  pulses;
    rst_n = 1'b0; tick_en = 1'b0; rate_sel = 4'd0; div_sel = 3'd2;
    pie_en = 1'b0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0);
    chk(per_flag == 1'b0 && req_pulse == 1'b0, "R1 reset outputs", {per_flag, req_pulse}, 0);

    // table walk: every code, alignment then spacing
    pie_en = 1'b1;
    for (int code = 1; code <= 15; code++) begin
      int p;
      p = int'(EXP_PER[code]);
      rate_sel = 4'(code);
      wait_event(2 * p + 4, 1'b0, tk, sn);
      chk(sn && (int'(m_cnt) % p == 0), "R5 event aligned to period multiple", int'(m_cnt) % p, 0);
      wait_event(2 * p + 4, 1'b0, tk, sn);
      if (code <= 2) chk(sn && tk == p, "R3 aliased code period", tk, p);
      else           chk(sn && tk == p, "R2 period from code", tk, p);
    end

    // R7: pulse one cycle wide, flag set with it; R8 flag holds without clear
    rate_sel = 4'd3;
    wait_event(12, 1'b0, tk, sn);
    chk(sn && per_flag, "R7 flag set with pulse", per_flag, 1);
    step(1'b0, 1'b0);
    chk(req_pulse == 1'b0, "R7 pulse one cycle", req_pulse, 0);
    repeat (5) step(1'b0, 1'b0);
    chk(per_flag == 1'b1, "R8 flag held", per_flag, 1);
    step(1'b0, 1'b1);
    chk(per_flag == 1'b0, "R8 flag cleared by strobe", per_flag, 0);

    // R8: clear coincident with event, set wins
    while (m_cnt % 4 != 3) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    chk(per_flag == 1'b1 && req_pulse == 1'b1, "R8 event beats clear", {per_flag, req_pulse}, 3);
    step(1'b0, 1'b1);

    // R4: code 0 gives nothing
    rate_sel = 4'd0;
    pulses = 0;
    for (int i = 0; i < 300; i++) begin step(1'b1, 1'b0); if (req_pulse) pulses++; end
    chk(pulses == 0 && per_flag == 1'b0, "R4 code zero silent", pulses, 0);

    // R6: enable low gives nothing
    rate_sel = 4'd3; pie_en = 1'b0;
    pulses = 0;
    for (int i = 0; i < 100; i++) begin step(1'b1, 1'b0); if (req_pulse || per_flag) pulses++; end
    chk(pulses == 0, "R6 disabled silent", pulses, 0);
    pie_en = 1'b1;

    // R5: code change takes effect from next tick
    rate_sel = 4'd5;
    wait_event(40, 1'b0, tk, sn);
    repeat (5) step(1'b1, 1'b0);
    rate_sel = 4'd3;
    wait_event(20, 1'b0, tk, sn);
    chk(sn && tk == 3, "R5 new code realigns", tk, 3);

    // R9: freeze keeps the count
    rate_sel = 4'd4;
    wait_event(20, 1'b0, tk, sn);
    step(1'b1, 1'b0); step(1'b1, 1'b0);
    div_sel = 3'd3;
    pulses = 0;
    for (int i = 0; i < 20; i++) begin step(1'b1, 1'b0); if (req_pulse) pulses++; end
    chk(pulses == 0, "R9 frozen no events", pulses, 0);
    div_sel = 3'd0;
    wait_event(20, 1'b0, tk, sn);
    chk(sn && tk == 6, "R9 frozen count resumes", tk, 6);

    // R9: divider clear zeroes the count
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
    div_sel = 3'd6;
    pulses = 0;
    for (int i = 0; i < 5; i++) begin step(1'b1, 1'b0); if (req_pulse) pulses++; end
    div_sel = 3'd1;
    wait_event(20, 1'b0, tk, sn);
    chk(pulses == 0 && sn && tk == 8, "R9 clear restarts from zero", tk, 8);

    // R10: only enabled ticks count
    rate_sel = 4'd3;
    wait_event(10, 1'b0, tk, sn);
    wait_event(20, 1'b1, tk, sn);
    chk(sn && tk == 4, "R10 sparse ticks", tk, 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule